// File: doc/BRIEF.md
# Flash Command Read-Mode Controller

This block is the command front end of a parallel NOR-style flash device. Byte-wide command writes arrive from the bus, and the block uses them to choose the source of every later read cycle. A read can return array data from the memory port, identifier codes, the status register, or the extended status register. The selected source stays in place until a new recognised command is written.

The status register combines live state from the write engine (ready and suspended) with four sticky error flags. The write engine raises these flags with one-cycle pulses. Only a clear command lowers them, and the block refuses that command while the engine is busy or suspended.

A status read captures its value when a read strobe first goes active. The value is then held until both strobes return high and a new read starts. While the write engine is busy and not suspended, array reads are refused: the block moves to status mode and ignores the array command. All inputs are sampled on the rising clock edge. The output is combinational from internal registers and the current inputs.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `pd_n` low, the read mode is array read. `pd_n` low takes priority over every command.
- R2: In array mode, `dout` equals `arr_data` whenever `pd_n`, `!ce_n` and `!oe_n` are all high. In every mode, `dout` is 0 whenever `ce_n` or `oe_n` is high, or `pd_n` is low.
- R3: The command codes are 0xFF (array), 0x90 (identifier), 0x70 (status) and 0xE8 (extended status). A command write with any other code leaves the read mode unchanged, and so does 0x50.
- R4: While `wsm_busy` is 1 and `wsm_susp` is 0, a 0xFF command is ignored. If the mode would be array in that state, it becomes status at the next edge. When `wsm_susp` is 1, 0xFF is accepted.
- R5: In identifier mode, address 0 returns 0x5A and address 1 returns 0xC3. Any other address whose low 4 bits equal 4 returns {6'b0, `blk_efail`, `blk_lock`}. Every other address returns 0.
- R6: The status value is {~`wsm_busy`, `wsm_susp`, S5, S4, S3, 0, S1, 0}, bits 7 down to 0. The sticky flags S5, S4, S3 and S1 are set by `err_set[3]`, `err_set[2]`, `err_set[1]` and `err_set[0]` respectively.
- R7: A sticky flag, once set, stays set until an accepted 0x50 command clears all four flags. If a set pulse and a clear arrive in the same cycle, the set wins.
- R8: A 0x50 command has no effect while `wsm_busy` or `wsm_susp` is 1.
- R9: The status latch loads the status value at the first clock edge where `ce_n` or `oe_n` is low after a cycle in which both were high. It holds that value while either strobe stays low. In status mode, `dout` shows the latch.
- R10: In extended status mode, `dout` shows a latch that loads `xsr_in` only on a 0xE8 command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Active-low deep power-down |
| cmd_we | input | 1 | Command write strobe, one cycle per command |
| cmd | input | 8 | Command code |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Read address |
| arr_data | input | 8 | Array data from the memory port |
| blk_lock | input | 1 | Lock state of the addressed block |
| blk_efail | input | 1 | Last erase of the addressed block failed |
| wsm_busy | input | 1 | Write engine running an operation |
| wsm_susp | input | 1 | Write engine operation suspended |
| err_set | input | 4 | Sticky error set pulses |
| xsr_in | input | 8 | Extended status value from the write engine |
| dout | output | 8 | Read data |

## Verification
The assertions assume that the write-engine inputs and the command strobe change only between clock edges. They also assume that `cmd` is meaningful only in cycles where `cmd_we` is high. The bench drives every input on the falling edge, and it raises `cmd_we` and `err_set` for exactly one cycle. It raises `wsm_susp` only in combinations that a real write engine could produce.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W = 8,
  parameter int OFF_W = 4,
  parameter logic [7:0] MFR_CODE = 8'h5A,
  parameter logic [7:0] DEV_CODE = 8'hC3,
  parameter logic [7:0] CMD_ARRAY = 8'hFF,
  parameter logic [7:0] CMD_IDENT = 8'h90,
  parameter logic [7:0] CMD_STATUS = 8'h70,
  parameter logic [7:0] CMD_CLEAR = 8'h50,
  parameter logic [7:0] CMD_XSTAT = 8'hE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              cmd_we,
  input  logic [7:0]        cmd,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        arr_data,
  input  logic              blk_lock,
  input  logic              blk_efail,
  input  logic              wsm_busy,
  input  logic              wsm_susp,
  input  logic [3:0]        err_set,
  input  logic [7:0]        xsr_in,
  output logic [7:0]        dout
);
  localparam logic [OFF_W-1:0] BLK_STAT_OFF = OFF_W'(4);

  typedef enum logic [1:0] {M_ARR, M_ID, M_SR, M_XSR} mode_t;

  mode_t      mode, mode_nxt;
  logic [3:0] sticky;
  logic [7:0] sr_lat, xsr_lat, sr_live, id_val;
  logic       strb, strb_q;

  wire locked_out = wsm_busy && !wsm_susp;
  wire clr_ok     = cmd_we && (cmd == CMD_CLEAR) && !wsm_busy && !wsm_susp;
  wire rd         = pd_n && !ce_n && !oe_n;

  assign strb    = !ce_n || !oe_n;
  assign sr_live = {~wsm_busy, wsm_susp, sticky[3], sticky[2], sticky[1], 1'b0, sticky[0], 1'b0};

  always_comb begin
    mode_nxt = mode;
    if (cmd_we) begin
      case (cmd)
        CMD_ARRAY:  if (!locked_out) mode_nxt = M_ARR;
        CMD_IDENT:  mode_nxt = M_ID;
        CMD_STATUS: mode_nxt = M_SR;
        CMD_XSTAT:  mode_nxt = M_XSR;
        default:    mode_nxt = mode;
      endcase
    end
    if (locked_out && mode_nxt == M_ARR) mode_nxt = M_SR;
    if (!pd_n) mode_nxt = M_ARR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= M_ARR;
      sticky  <= '0;
      sr_lat  <= '0;
      xsr_lat <= '0;
      strb_q  <= 1'b0;
    end else begin
      mode   <= mode_nxt;
      sticky <= (clr_ok ? 4'b0 : sticky) | err_set;
      strb_q <= strb;
      if (strb && !strb_q) sr_lat <= sr_live;
      if (cmd_we && cmd == CMD_XSTAT) xsr_lat <= xsr_in;
    end
  end

  always_comb begin
    if (addr == '0)                         id_val = MFR_CODE;
    else if (addr == ADDR_W'(1))            id_val = DEV_CODE;
    else if (addr[OFF_W-1:0] == BLK_STAT_OFF) id_val = {6'b0, blk_efail, blk_lock};
    else                                    id_val = 8'h00;
  end

  always_comb begin
    dout = 8'h00;
    if (rd) begin
      case (mode)
        M_ARR:   dout = arr_data;
        M_ID:    dout = id_val;
        M_SR:    dout = sr_lat;
        default: dout = xsr_lat;
      endcase
    end
  end

  a_r1_pd_array: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> mode == M_ARR);

  a_r3_unknown_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && !locked_out && cmd_we && cmd != CMD_ARRAY && cmd != CMD_IDENT &&
     cmd != CMD_STATUS && cmd != CMD_XSTAT) |=> $stable(mode));

  a_r4_busy_no_array: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && wsm_busy && !wsm_susp) |=> mode != M_ARR);

  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ok |=> (sticky & $past(sticky)) == $past(sticky));

  a_r8_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd == CMD_CLEAR && (wsm_busy || wsm_susp)) |=> (sticky & $past(sticky)) == $past(sticky));

  a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_q && strb) |=> $stable(sr_lat));

  a_r10_xsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_we && cmd == CMD_XSTAT) |=> $stable(xsr_lat));
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n, pd_n, cmd_we, ce_n, oe_n, blk_lock, blk_efail, wsm_busy, wsm_susp;
  logic [7:0] cmd, addr, xsr_in, dout, arr_data;
  logic [3:0] err_set;

  assign arr_data = addr ^ 8'hA5;

  flash_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cmd_we(cmd_we), .cmd(cmd),
    .ce_n(ce_n), .oe_n(oe_n), .addr(addr), .arr_data(arr_data),
    .blk_lock(blk_lock), .blk_efail(blk_efail), .wsm_busy(wsm_busy),
    .wsm_susp(wsm_susp), .err_set(err_set), .xsr_in(xsr_in), .dout(dout)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  int m;
  logic [3:0] st;
  logic [7:0] srl, xl;
  bit sq;

  function automatic logic [7:0] model_out();
    if (!pd_n || ce_n || oe_n) return 8'h00;
    case (m)
      0: return addr ^ 8'hA5;
      1: begin
        if (addr == 8'h00) return 8'h5A;
        if (addr == 8'h01) return 8'hC3;
        if (addr[3:0] == 4'h4) return {6'b0, blk_efail, blk_lock};
        return 8'h00;
      end
      2: return srl;
      default: return xl;
    endcase
  endfunction

  task automatic step();
    logic [7:0] now;
    bit s, clr;
    if (!rst_n) begin
      m = 0; st = 0; srl = 0; xl = 0; sq = 0;
      return;
    end
    now = {~wsm_busy, wsm_susp, st[3], st[2], st[1], 1'b0, st[0], 1'b0};
    s = !ce_n || !oe_n;
    if (s && !sq) srl = now;
    sq = s;
    if (cmd_we && cmd == 8'hE8) xl = xsr_in;
    clr = cmd_we && cmd == 8'h50 && !wsm_busy && !wsm_susp;
    st = (clr ? 4'b0 : st) | err_set;
    if (!pd_n) m = 0;
    else begin
      if (cmd_we) begin
        if (cmd == 8'hFF && !(wsm_busy && !wsm_susp)) m = 0;
        else if (cmd == 8'h90) m = 1;
        else if (cmd == 8'h70) m = 2;
        else if (cmd == 8'hE8) m = 3;
      end
      if (wsm_busy && !wsm_susp && m == 0) m = 2;
    end
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    string tags[4] = '{"R2", "R5", "R9", "R10"};
    step();
    @(posedge clk);
    @(negedge clk);
    chk(tags[m], dout, model_out());
  endtask

  task automatic wr(logic [7:0] c);
    cmd_we = 1; cmd = c; tick(); cmd_we = 0; cmd = 8'h00;
  endtask

  task automatic pulse(logic [3:0] e);
    err_set = e; tick(); err_set = 0;
  endtask

  task automatic reread();
    ce_n = 1; oe_n = 1; tick();
    ce_n = 0; oe_n = 0; tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual running expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; pd_n = 1; cmd_we = 0; cmd = 0; ce_n = 1; oe_n = 1; addr = 0;
    blk_lock = 0; blk_efail = 0; wsm_busy = 0; wsm_susp = 0; err_set = 0; xsr_in = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R2", dout, 8'h00);
    ce_n = 0; oe_n = 0; addr = 8'h3C; tick();
    chk("R1", dout, 8'h99);
    for (int i = 0; i < 6; i++) begin addr = 8'(i * 37); tick(); end
    oe_n = 1; tick();
    chk("R2", dout, 8'h00);
    oe_n = 0;

    wr(8'h90);
    addr = 8'h00; tick(); chk("R5", dout, 8'h5A);
    addr = 8'h01; tick(); chk("R5", dout, 8'hC3);
    addr = 8'h24; blk_lock = 1; tick(); chk("R5", dout, 8'h01);
    addr = 8'h34; blk_lock = 0; blk_efail = 1; tick(); chk("R5", dout, 8'h02);
    addr = 8'h02; tick(); chk("R5", dout, 8'h00);
    wr(8'h12);
    addr = 8'h00; tick(); chk("R3", dout, 8'h5A);

    wr(8'h70);
    pulse(4'b0001);
    reread(); chk("R6", dout, 8'h82);
    pulse(4'b0100);
    tick(); chk("R9", dout, 8'h82);
    reread(); chk("R7", dout, 8'h92);
    pulse(4'b0100);
    reread(); chk("R7", dout, 8'h92);

    wsm_busy = 1; tick();
    reread(); chk("R6", dout, 8'h12);
    wr(8'hFF);
    tick(); chk("R4", dout, 8'h12);
    wr(8'h50);
    wsm_busy = 0;
    reread(); chk("R8", dout, 8'h92);
    wsm_susp = 1;
    wr(8'h50);
    reread(); chk("R8", dout, 8'hD2);
    wsm_susp = 0;
    wr(8'h50);
    reread(); chk("R7", dout, 8'h80);
    cmd_we = 1; cmd = 8'h50; err_set = 4'b1000; tick();
    cmd_we = 0; err_set = 0;
    reread(); chk("R7", dout, 8'hA0);

    xsr_in = 8'h3E; wr(8'hE8);
    tick(); chk("R10", dout, 8'h3E);
    xsr_in = 8'h11; tick(); tick(); chk("R10", dout, 8'h3E);
    wr(8'hE8); chk("R10", dout, 8'h11);

    wr(8'hFF);
    addr = 8'h5A; tick(); chk("R3", dout, 8'hFF);
    wsm_busy = 1; tick();
    reread(); chk("R4", dout, 8'h20);
    wsm_susp = 1; wr(8'hFF);
    tick(); chk("R4", dout, 8'hFF);
    wsm_busy = 0; wsm_susp = 0; tick();

    wr(8'h90);
    pd_n = 0; tick(); chk("R2", dout, 8'h00);
    wr(8'h70);
    pd_n = 1; tick(); chk("R1", dout, 8'hFF);

    for (int i = 0; i < 40; i++) begin
      addr = 8'(i * 13);
      ce_n = i[0]; oe_n = i[2];
      if (i % 7 == 0) wr(8'h90);
      else if (i % 11 == 0) wr(8'h70);
      else tick();
    end

    done = 1;
    finish_run();
  end
endmodule